// File: doc/BRIEF.md
# Serial-Programmed Wiper Position Controller

This block is the digital core of a serially programmed variable resistor. A three-wire port is made up of an active-low select, a serial clock and serial data. While select is low, the block shifts a word into an input register, most significant bit first. When select rises, it copies that word into a position latch. The latch is decoded into a one-hot tap-select vector, where bit 0 is the tap at the B end and each higher bit is one step closer to the A end. The block also drives two switch controls: one opens the A-end switch and one shorts the wiper to the B end.

The parameter `FULL_LADDER` chooses between two variants. The full variant has an 8-bit word and 256 taps and presets to code 128. The reduced variant has a 6-bit word and 33 taps and presets to code 16. In the reduced variant, codes above 32 saturate to the top tap. An active-low shutdown input opens the A switch, shorts the wiper to B and blanks the tap vector. During shutdown the latch keeps its value and the serial port keeps working, so a code loaded during shutdown takes effect when shutdown is released. All pin inputs pass through two-stage synchronisers into the system clock domain. Edges are found from the synchronised samples.

There are two state machines.

The serial machine has three states:
- `SER_IDLE`: select is high.
- `SER_ARMED`: select is low, and each serial clock rise shifts one bit.
- `SER_COMMIT`: a one-cycle load of the latch.

Its transitions are:
- IDLE to ARMED when the synchronised select is low.
- ARMED to COMMIT when it goes high.
- COMMIT to ARMED or IDLE, according to the select level.

The power machine has two states, `PWR_ACTIVE` and `PWR_SHUTDOWN`. It moves to shutdown when the synchronised shutdown input is low and returns to active when it is high.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: After reset, the latch holds midscale: 128 for the full variant, 16 for the reduced variant. The outputs show that tap, with the A switch closed and no wiper short.
- R2: While select is low, each serial clock rise shifts in one data bit, first bit most significant. On the rising edge of select, the input register is copied to the latch. Output bit i of `tap_sel` is then the only bit set, where i is the code.
- R3: In the reduced variant, codes 33 through 63 select tap 32, the same tap as code 32.
- R4: While select is high, serial clock and data activity leaves the input register unchanged. A select pulse with no clock edges therefore reloads the previous word.
- R5: A frame with fewer clock edges than the word width loads the register as it stands, which is the old contents shifted left by the number of bits received.
- R6: While shutdown is low, `tap_sel` is all zero, `a_switch_open` is 1 and `wiper_b_short` is 1.
- R7: A word shifted in and committed during shutdown appears on `tap_sel` once shutdown is released.
- R8: The latch value is kept through shutdown and shows again on release.
- R9: Code 0 selects bit 0, the B end. At most one bit of `tap_sel` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, acts as power-on preset |
| cs_n | input | 1 | Active-low serial select; its rising edge commits the word |
| sclk | input | 1 | Serial clock; rising edges shift data |
| sdi | input | 1 | Serial data, most significant bit first |
| shdn_n | input | 1 | Active-low shutdown |
| tap_sel | output | TAPS | One-hot tap select; bit 0 is the B end |
| wiper_b_short | output | 1 | Shorts the wiper to the B end |
| a_switch_open | output | 1 | Opens the A-end switch |

## Verification
A wrong bit order in the input register, a missed or extra shift, or a bad saturation compare shows up as the wrong `tap_sel` bit. This is visible a few system clocks after select rises, because the path is two synchroniser stages, the commit state and the latch. A shift register that moves while select is high is caught by reloading the word with an empty frame. Loss of latch contents during shutdown appears as a wrong tap on the cycle after shutdown is released.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [1:0] {
        SER_IDLE   = 2'd0,
        SER_ARMED  = 2'd1,
        SER_COMMIT = 2'd2
    } ser_state_e;

    typedef enum logic {
        PWR_ACTIVE   = 1'b0,
        PWR_SHUTDOWN = 1'b1
    } pwr_state_e;

    function automatic int word_bits(input bit full);
        return full ? 8 : 6;
    endfunction

    function automatic int tap_count(input bit full);
        return full ? 256 : 33;
    endfunction

    function automatic int mid_code(input bit full);
        return full ? 128 : 16;
    endfunction

endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/wpc_serial_fsm.sv
module wpc_serial_fsm
    import wpc_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int PRESET_V = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output ser_state_e        state,
    output logic [WORD_W-1:0] shift_q,
    output logic [WORD_W-1:0] pos_q
);
    ser_state_e next_state;
    logic       sclk_d;
    logic       sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_d;

    always_comb begin
        next_state = state;
        unique case (state)
            SER_IDLE:   if (!cs_s) next_state = SER_ARMED;
            SER_ARMED:  if (cs_s)  next_state = SER_COMMIT;
            SER_COMMIT: next_state = cs_s ? SER_IDLE : SER_ARMED;
            default:    next_state = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SER_IDLE;
        end else begin
            state <= next_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            shift_q <= '0;
            pos_q   <= WORD_W'(PRESET_V);
        end else begin
            sclk_d <= sclk_s;
            if (state == SER_ARMED && !cs_s && sclk_rise) begin
                shift_q <= {shift_q[WORD_W-2:0], sdi_s};
            end
            if (state == SER_COMMIT) begin
                pos_q <= shift_q;
            end
        end
    end
endmodule

// File: rtl/wpc_tap_decode.sv
module wpc_tap_decode #(
    parameter int WORD_W = 8,
    parameter int TAPS   = 256
) (
    input  logic [WORD_W-1:0] code,
    output logic [TAPS-1:0]   taps
);
    localparam int            CODE_SPAN = 1 << WORD_W;
    localparam logic [WORD_W-1:0] TOP   = WORD_W'(TAPS - 1);

    logic [WORD_W-1:0] eff_code;

    generate
        if (TAPS < CODE_SPAN) begin : g_saturate
            assign eff_code = (code > TOP) ? TOP : code;
        end else begin : g_direct
            assign eff_code = code;
        end
    endgenerate

    generate
        for (genvar i = 0; i < TAPS; i++) begin : g_tap
            assign taps[i] = (eff_code == WORD_W'(i));
        end
    endgenerate
endmodule

// File: rtl/wpc_power_fsm.sv
module wpc_power_fsm
    import wpc_pkg::*;
#(
    parameter int TAPS = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shdn_s,
    input  logic [TAPS-1:0] taps_in,
    output logic [TAPS-1:0] tap_sel,
    output logic            wiper_b_short,
    output logic            a_switch_open
);
    pwr_state_e state;
    pwr_state_e next_state;

    always_comb begin
        next_state = state;
        unique case (state)
            PWR_ACTIVE:   if (!shdn_s) next_state = PWR_SHUTDOWN;
            PWR_SHUTDOWN: if (shdn_s)  next_state = PWR_ACTIVE;
            default:      next_state = PWR_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PWR_ACTIVE;
        end else begin
            state <= next_state;
        end
    end

    always_comb begin
        unique case (state)
            PWR_SHUTDOWN: begin
                tap_sel       = '0;
                wiper_b_short = 1'b1;
                a_switch_open = 1'b1;
            end
            default: begin
                tap_sel       = taps_in;
                wiper_b_short = 1'b0;
                a_switch_open = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl
    import wpc_pkg::*;
#(
    parameter bit FULL_LADDER = 1'b1,
    localparam int WORD_W = word_bits(FULL_LADDER),
    localparam int TAPS   = tap_count(FULL_LADDER)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic            sdi,
    input  logic            shdn_n,
    output logic [TAPS-1:0] tap_sel,
    output logic            wiper_b_short,
    output logic            a_switch_open
);
    localparam int PRESET_V = mid_code(FULL_LADDER);

    logic [3:0]        pins_s;
    logic              cs_s, sclk_s, sdi_s, shdn_s;
    ser_state_e        ser_state;
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] pos_q;
    logic [TAPS-1:0]   taps_raw;

    wpc_sync #(.W(4), .RST_VAL(4'b1001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdi, shdn_n}),
        .q     (pins_s)
    );

    assign {cs_s, sclk_s, sdi_s, shdn_s} = pins_s;

    wpc_serial_fsm #(.WORD_W(WORD_W), .PRESET_V(PRESET_V)) u_serial (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .sclk_s  (sclk_s),
        .sdi_s   (sdi_s),
        .state   (ser_state),
        .shift_q (shift_q),
        .pos_q   (pos_q)
    );

    wpc_tap_decode #(.WORD_W(WORD_W), .TAPS(TAPS)) u_decode (
        .code (pos_q),
        .taps (taps_raw)
    );

    wpc_power_fsm #(.TAPS(TAPS)) u_power (
        .clk           (clk),
        .rst_n         (rst_n),
        .shdn_s        (shdn_s),
        .taps_in       (taps_raw),
        .tap_sel       (tap_sel),
        .wiper_b_short (wiper_b_short),
        .a_switch_open (a_switch_open)
    );
endmodule

// File: rtl/wiper_pos_ctrl_checker.sv
module wiper_pos_ctrl_checker
    import wpc_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int TAPS   = 256
) (
    input logic              clk,
    input logic              rst_n,
    input ser_state_e        ser_state,
    input logic [WORD_W-1:0] shift_q,
    input logic [WORD_W-1:0] pos_q,
    input logic              shdn_s,
    input logic [TAPS-1:0]   tap_sel,
    input logic              wiper_b_short,
    input logic              a_switch_open
);
    // R4: no shifting while select is high
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_state == SER_IDLE) |=> $stable(shift_q));

    // R8: latch moves only out of the commit state
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_state != SER_COMMIT) |=> $stable(pos_q));

    // R6: synchronised shutdown forces the switch pattern next cycle
    a_r6_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_s |=> (a_switch_open && wiper_b_short && tap_sel == '0));

    // R9: one tap when running
    a_r9_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_s |=> (!a_switch_open && $countones(tap_sel) == 1));

    generate
        if (TAPS < (1 << WORD_W)) begin : g_sat
            // R3: out-of-range codes land on the top tap
            a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
                (pos_q > WORD_W'(TAPS - 1) && !a_switch_open) |-> tap_sel[TAPS-1]);
        end
    endgenerate
endmodule

bind wiper_pos_ctrl wiper_pos_ctrl_checker #(.WORD_W(WORD_W), .TAPS(TAPS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_state     (ser_state),
    .shift_q       (shift_q),
    .pos_q         (pos_q),
    .shdn_s        (shdn_s),
    .tap_sel       (tap_sel),
    .wiper_b_short (wiper_b_short),
    .a_switch_open (a_switch_open)
);

// File: tb/wiper_pos_ctrl_bench.sv
module wiper_pos_ctrl_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, shdn_n = 1'b1;
    logic use_small = 1'b0;

    logic f_cs, f_sclk, f_sdi, f_shdn, s_cs, s_sclk, s_sdi, s_shdn;
    assign f_cs   = use_small ? 1'b1 : cs_n;
    assign f_sclk = use_small ? 1'b0 : sclk;
    assign f_sdi  = use_small ? 1'b0 : sdi;
    assign f_shdn = use_small ? 1'b1 : shdn_n;
    assign s_cs   = use_small ? cs_n   : 1'b1;
    assign s_sclk = use_small ? sclk   : 1'b0;
    assign s_sdi  = use_small ? sdi    : 1'b0;
    assign s_shdn = use_small ? shdn_n : 1'b1;

    logic [255:0] f_tap;
    logic         f_short, f_open;
    logic [32:0]  s_tap;
    logic         s_short, s_open;

    wiper_pos_ctrl #(.FULL_LADDER(1'b1)) u_wiper_pos_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(f_cs), .sclk(f_sclk), .sdi(f_sdi),
        .shdn_n(f_shdn), .tap_sel(f_tap), .wiper_b_short(f_short),
        .a_switch_open(f_open)
    );

    wiper_pos_ctrl #(.FULL_LADDER(1'b0)) u_wiper_pos_ctrl_small (
        .clk(clk), .rst_n(rst_n), .cs_n(s_cs), .sclk(s_sclk), .sdi(s_sdi),
        .shdn_n(s_shdn), .tap_sel(s_tap), .wiper_b_short(s_short),
        .a_switch_open(s_open)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_run(input int idx, input string req);
        n_checks++;
        if (!use_small) begin
            logic [255:0] exp;
            exp = '0;
            exp[idx] = 1'b1;
            if (f_tap !== exp || f_short !== 1'b0 || f_open !== 1'b0) begin
                n_fail++;
                $display("FAIL %s: tap=%h short=%b open=%b expected tap=%h short=0 open=0",
                         req, f_tap, f_short, f_open, exp);
            end
        end else begin
            logic [32:0] exp;
            exp = '0;
            exp[idx] = 1'b1;
            if (s_tap !== exp || s_short !== 1'b0 || s_open !== 1'b0) begin
                n_fail++;
                $display("FAIL %s: tap=%h short=%b open=%b expected tap=%h short=0 open=0",
                         req, s_tap, s_short, s_open, exp);
            end
        end
    endtask

    task automatic check_shut(input string req);
        n_checks++;
        if (!use_small) begin
            if (f_tap !== '0 || f_short !== 1'b1 || f_open !== 1'b1) begin
                n_fail++;
                $display("FAIL %s: tap=%h short=%b open=%b expected tap=0 short=1 open=1",
                         req, f_tap, f_short, f_open);
            end
        end else begin
            if (s_tap !== '0 || s_short !== 1'b1 || s_open !== 1'b1) begin
                n_fail++;
                $display("FAIL %s: tap=%h short=%b open=%b expected tap=0 short=1 open=1",
                         req, s_tap, s_short, s_open);
            end
        end
    endtask

    task automatic send(input int nbits, input logic [7:0] val);
        cs_n = 1'b0;
        cyc(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = val[i];
            cyc(4);
            sclk = 1'b1;
            cyc(4);
            sclk = 1'b0;
        end
        cyc(4);
        cs_n = 1'b1;
        sdi  = 1'b0;
        cyc(10);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(4);

        // R1: midscale preset on both variants
        use_small = 1'b0; check_run(128, "R1");
        use_small = 1'b1; check_run(16, "R1");

        // R2 / R9: full sweep of the 256-tap variant
        use_small = 1'b0;
        for (int c = 0; c < 256; c++) begin
            send(8, 8'(c));
            check_run(c, (c == 0) ? "R9" : "R2");
        end

        // R2 / R3: all 6-bit codes on the 33-tap variant
        use_small = 1'b1;
        cyc(2);
        for (int c = 0; c < 64; c++) begin
            send(6, 8'(c));
            check_run((c > 32) ? 32 : c, (c > 32) ? "R3" : "R2");
        end

        // R4: clock activity with select high is ignored
        use_small = 1'b0;
        cyc(2);
        send(8, 8'h3C);
        check_run(8'h3C, "R4");
        for (int k = 0; k < 10; k++) begin
            sdi = k[0];
            cyc(4);
            sclk = 1'b1;
            cyc(4);
            sclk = 1'b0;
        end
        sdi = 1'b0;
        cyc(6);
        check_run(8'h3C, "R4");
        send(0, 8'h00);
        check_run(8'h3C, "R4");

        // R5: short frame loads shifted register as it stands
        send(8, 8'hA5);
        send(3, 8'h06);
        check_run(((8'hA5 << 3) | 6) & 8'hFF, "R5");

        // R6 / R8: shutdown and retention
        shdn_n = 1'b0;
        cyc(8);
        check_shut("R6");
        shdn_n = 1'b1;
        cyc(8);
        check_run(8'h2E, "R8");

        // R7: load during shutdown
        shdn_n = 1'b0;
        cyc(8);
        send(8, 8'h71);
        check_shut("R7");
        shdn_n = 1'b1;
        cyc(8);
        check_run(8'h71, "R7");

        // R6 / R7 / R8 on the small variant
        use_small = 1'b1;
        cyc(2);
        send(6, 8'h25);
        check_run(32, "R3");
        shdn_n = 1'b0;
        cyc(8);
        check_shut("R6");
        shdn_n = 1'b1;
        cyc(8);
        check_run(32, "R8");
        shdn_n = 1'b0;
        cyc(8);
        send(6, 8'h05);
        check_shut("R7");
        shdn_n = 1'b1;
        cyc(8);
        check_run(5, "R7");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule